// File: doc/BRIEF.md
# Three-Toggle PWM Channel

This block drives one pulse-width-modulated output from a free-running period counter. Each period lasts a programmed number of clock cycles. The output starts every period at a programmed level and inverts at up to three programmed cycle offsets within it. Software-facing logic writes these values into a staging set through a small write port. The staging set has no effect until a load strobe arrives. A load moves the values into a pending set after a consistency check. The pending set becomes active at the next period rollover, or at once while the channel is stopped.

The two duty corner cases are handled in hardware. A first toggle of zero gives a constant low output. A first toggle equal to the period gives a constant high output. In both cases the programmed initial level is ignored. A status flag is raised at each period end and drives the interrupt line while the interrupt is enabled. Start, stop, interrupt enable, interrupt disable and status acknowledge are single-cycle strobes.

Top module: `tri_edge_pwm`

## Requirements
- R1: After reset, `pwm_out`, `irq` and `err` are all low, and the active set holds a period of 1 with all toggle points at zero.
- R2: While running, the counter steps from 0 to P-1 and wraps, where P is the active period. At counter value c, the output equals the effective initial level inverted once for each nonzero toggle point Tk with c >= Tk. The counter is 0 in the first cycle after the start strobe is taken.
- R3: A toggle point of zero never causes an inversion. This applies to the second and third toggle points as well as to the first.
- R4: When the first toggle point is zero, the effective initial level is low, whatever initial level was programmed.
- R5: When the first toggle point equals the period, the effective initial level is high, whatever initial level was programmed.
- R6: A write with `wr_en` changes only the staging set. Select 0, 1 and 2 write toggle points one to three, select 3 writes the period, and select 4 writes the initial level from `wr_data[0]`. The waveform does not change until a load is taken.
- R7: While the channel runs, an accepted load takes effect at the next period rollover, and the current period completes with the old values. While the channel is stopped, an accepted load is active two clock edges after the strobe.
- R8: A load is rejected if the staged period is zero, if the first toggle point exceeds the period, or if a nonzero second or third toggle point is above the period or not above every earlier toggle point. A rejected load sets `err` and leaves the active set unchanged. An accepted load clears `err`.
- R9: The status flag is set at every period end, and `irq` is the status flag ANDed with the interrupt enable. `irq_ack` clears the status flag, but a period end in the same cycle wins.
- R10: An interrupt enable strobe is ignored while the channel is stopped. A disable strobe clears both the enable and the status flag.
- R11: A stop strobe returns the counter to zero, so the output shows the effective initial level. A start strobe while running has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Staging write strobe |
| wr_sel | input | 3 | Staging field select (0-2 toggles, 3 period, 4 initial level) |
| wr_data | input | 8 | Staging write data, in cycles |
| load_req | input | 1 | Check the staged set and move it to pending |
| start_req | input | 1 | Start the counter |
| stop_req | input | 1 | Stop the counter and clear it to zero |
| irq_en_req | input | 1 | Enable the interrupt (only taken while running) |
| irq_dis_req | input | 1 | Disable the interrupt and clear the status flag |
| irq_ack | input | 1 | Clear the status flag |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |
| err | output | 1 | The last load was rejected |

## Verification
The hardest case to reach is an update in mid-period. A load arrives while the counter is part-way through a period, and it must take effect exactly at the following wrap with no shortened or stretched period. The stimulus starts a long period and counts cycles from the start strobe. It writes a new first toggle point and strobes the load at a known counter value. Every cycle of the old tail and of the next period is then compared against the old and new waveforms. A redundant start strobe is injected in the same run. The other hard case is a period end that coincides with an acknowledge. The stimulus places the acknowledge in the cycle where the counter sits at its last value.

// File: rtl/tep_pkg.sv
package tep_pkg;

    // Command strobes gathered for internal routing
    typedef struct packed {
        logic load;
        logic start;
        logic stop;
        logic ien;
        logic idis;
        logic ack;
    } tep_cmd_t;

endpackage

// File: rtl/tep_cfg_check.sv
module tep_cfg_check #(
    parameter int CNT_W = 8,
    parameter int NTOG  = 3
) (
    input  logic [NTOG-1:0][CNT_W-1:0] tog,
    input  logic [CNT_W-1:0]           per,
    output logic                       ok
);

    always_comb begin
        ok = (per != '0) && (tog[0] <= per);
        for (int k = 1; k < NTOG; k++) begin
            if (tog[k] != '0) begin
                if (tog[k] > per) ok = 1'b0;
                for (int j = 0; j < k; j++) begin
                    if (tog[k] <= tog[j]) ok = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/tep_timebase.sv
module tep_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] per,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             period_end
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tb_st_t;

    tb_st_t st_d, st_q;

    assign period_end = st_q.run && (st_q.cnt == per - CNT_W'(1));
    assign run        = st_q.run;
    assign cnt        = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (stop_req) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (start_req && !st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            st_d.cnt = period_end ? '0 : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the running counter never reaches the active period
    p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt < per));

    // R11: a stop leaves the counter idle at zero
    p_stop_zeroes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (!st_q.run && st_q.cnt == '0));

endmodule

// File: rtl/tep_shadow.sv
module tep_shadow #(
    parameter int CNT_W = 8,
    parameter int NTOG  = 3,
    parameter int SEL_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [CNT_W-1:0]           wr_data,
    input  logic                       load_req,
    input  logic                       stg_ok,
    input  logic                       run,
    input  logic                       period_end,
    output logic [NTOG-1:0][CNT_W-1:0] stg_tog,
    output logic [CNT_W-1:0]           stg_per,
    output logic [NTOG-1:0][CNT_W-1:0] act_tog,
    output logic [CNT_W-1:0]           act_per,
    output logic                       act_init,
    output logic                       err
);

    localparam logic [SEL_W-1:0] SEL_PER  = SEL_W'(NTOG);
    localparam logic [SEL_W-1:0] SEL_INIT = SEL_W'(NTOG + 1);

    typedef struct packed {
        logic [NTOG-1:0][CNT_W-1:0] tog;
        logic [CNT_W-1:0]           per;
        logic                       init;
    } tset_t;

    typedef struct packed {
        tset_t stg;
        tset_t pnd;
        logic  pnd_vld;
        tset_t act;
        logic  err;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // pending set becomes active on a rollover, or at once when idle
        if (st_q.pnd_vld && (period_end || !run)) begin
            st_d.act     = st_q.pnd;
            st_d.pnd_vld = 1'b0;
        end
        if (load_req) begin
            if (stg_ok) begin
                st_d.pnd     = st_q.stg;
                st_d.pnd_vld = 1'b1;
                st_d.err     = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
        if (wr_en) begin
            for (int k = 0; k < NTOG; k++) begin
                if (wr_sel == SEL_W'(k)) st_d.stg.tog[k] = wr_data;
            end
            if (wr_sel == SEL_PER)  st_d.stg.per  = wr_data;
            if (wr_sel == SEL_INIT) st_d.stg.init = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.stg.per <= CNT_W'(1);
            st_q.pnd.per <= CNT_W'(1);
            st_q.act.per <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign stg_tog  = st_q.stg.tog;
    assign stg_per  = st_q.stg.per;
    assign act_tog  = st_q.act.tog;
    assign act_per  = st_q.act.per;
    assign act_init = st_q.act.init;
    assign err      = st_q.err;

    // R7: active values hold steady inside a running period
    p_no_midperiod_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !period_end) |=> $stable(st_q.act));

    // R8: a rejected load raises the error flag
    p_reject_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !stg_ok) |=> st_q.err);

    // R8: the active period is never zero
    p_active_period_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act.per != '0);

endmodule

// File: rtl/tep_wave.sv
module tep_wave #(
    parameter int CNT_W = 8,
    parameter int NTOG  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [NTOG-1:0][CNT_W-1:0] tog,
    input  logic [CNT_W-1:0]           per,
    input  logic                       init_lvl,
    output logic                       wave
);

    logic [NTOG-1:0] passed;
    logic            lvl_eff;

    for (genvar k = 0; k < NTOG; k++) begin : g_tog
        assign passed[k] = (tog[k] != '0) && (cnt >= tog[k]);
    end

    always_comb begin
        if (tog[0] == '0)     lvl_eff = 1'b0;
        else if (tog[0] == per) lvl_eff = 1'b1;
        else                  lvl_eff = init_lvl;
    end

    assign wave = lvl_eff ^ (^passed);

    // R4: zero first toggle gives a low period start
    p_zero_duty_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && tog[0] == '0) |-> !wave);

    // R5: full first toggle gives a high period start
    p_full_duty_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && tog[0] == per) |-> wave);

endmodule

// File: rtl/tri_edge_pwm.sv
module tri_edge_pwm #(
    parameter int CNT_W = 8,
    parameter int NTOG  = 3,
    parameter int SEL_W = $clog2(NTOG + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_req,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             irq_en_req,
    input  logic             irq_dis_req,
    input  logic             irq_ack,
    output logic             pwm_out,
    output logic             irq,
    output logic             err
);

    import tep_pkg::*;

    tep_cmd_t cmd;
    assign cmd = '{load: load_req, start: start_req, stop: stop_req,
                   ien: irq_en_req, idis: irq_dis_req, ack: irq_ack};

    logic [NTOG-1:0][CNT_W-1:0] stg_tog, act_tog;
    logic [CNT_W-1:0]           stg_per, act_per, cnt;
    logic                       act_init, stg_ok, run, period_end;

    tep_cfg_check #(.CNT_W(CNT_W), .NTOG(NTOG)) u_check (
        .tog (stg_tog),
        .per (stg_per),
        .ok  (stg_ok)
    );

    tep_shadow #(.CNT_W(CNT_W), .NTOG(NTOG), .SEL_W(SEL_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .load_req   (cmd.load),
        .stg_ok     (stg_ok),
        .run        (run),
        .period_end (period_end),
        .stg_tog    (stg_tog),
        .stg_per    (stg_per),
        .act_tog    (act_tog),
        .act_per    (act_per),
        .act_init   (act_init),
        .err        (err)
    );

    tep_timebase #(.CNT_W(CNT_W)) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (cmd.start),
        .stop_req   (cmd.stop),
        .per        (act_per),
        .run        (run),
        .cnt        (cnt),
        .period_end (period_end)
    );

    tep_wave #(.CNT_W(CNT_W), .NTOG(NTOG)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .tog      (act_tog),
        .per      (act_per),
        .init_lvl (act_init),
        .wave     (pwm_out)
    );

    typedef struct packed {
        logic ien;
        logic sts;
    } irq_st_t;

    irq_st_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (period_end)   ir_d.sts = 1'b1;
        else if (cmd.ack) ir_d.sts = 1'b0;
        if (cmd.idis) begin
            ir_d.ien = 1'b0;
            ir_d.sts = 1'b0;
        end else if (cmd.ien && run) begin
            ir_d.ien = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign irq = ir_q.ien & ir_q.sts;

    // R10: disable leaves the interrupt line low
    p_disable_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dis_req |=> !irq);

    // R10: an enable taken while idle does nothing
    p_idle_enable_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_req && !run && !ir_q.ien && !irq_dis_req) |=> !ir_q.ien);

    // R9: a period end always leaves status set unless disabled
    p_end_sets_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !irq_dis_req) |=> ir_q.sts);

endmodule

// File: tb/tri_edge_pwm_test.sv
module tri_edge_pwm_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic         load_req = 1'b0, start_req = 1'b0, stop_req = 1'b0;
    logic         irq_en_req = 1'b0, irq_dis_req = 1'b0, irq_ack = 1'b0;
    logic         pwm_out, irq, err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_edge_pwm #(.CNT_W(W), .NTOG(3)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .load_req(load_req), .start_req(start_req), .stop_req(stop_req),
        .irq_en_req(irq_en_req), .irq_dis_req(irq_dis_req), .irq_ack(irq_ack),
        .pwm_out(pwm_out), .irq(irq), .err(err)
    );

    function automatic bit lvl_of(int t1, int t2, int t3, int t4, bit init, int c);
        bit e;
        int n;
        e = (t1 == 0) ? 1'b0 : (t1 == t4) ? 1'b1 : init;
        n = 0;
        if (t1 != 0 && c >= t1) n++;
        if (t2 != 0 && c >= t2) n++;
        if (t3 != 0 && c >= t3) n++;
        return e ^ n[0];
    endfunction

    function automatic bit cfg_valid(int t1, int t2, int t3, int t4);
        if (t4 == 0 || t1 > t4) return 1'b0;
        if (t2 != 0 && (t2 > t4 || t2 <= t1)) return 1'b0;
        if (t3 != 0 && (t3 > t4 || t3 <= t1 || t3 <= t2)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input bit act, input bit exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int sel, input int val);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = W'(val);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic stage(input int t1, input int t2, input int t3, input int t4, input bit init);
        wr(0, t1); wr(1, t2); wr(2, t3); wr(3, t4); wr(4, int'(init));
    endtask

    task automatic do_load();
        load_req = 1'b1; tick(); load_req = 1'b0;
    endtask

    task automatic do_start();
        start_req = 1'b1; tick(); start_req = 1'b0;
    endtask

    task automatic do_stop();
        stop_req = 1'b1; tick(); stop_req = 1'b0;
    endtask

    task automatic run_check(input int t1, input int t2, input int t3, input int t4,
                             input bit init, input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            chk(pwm_out, lvl_of(t1, t2, t3, t4, init, i % t4), tag);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(pwm_out, 1'b0, "R1 pwm");
        chk(irq, 1'b0, "R1 irq");
        chk(err, 1'b0, "R1 err");

        // R2 R3 R4 R5 R11: sweep every valid small configuration
        for (int t4 = 1; t4 <= 6; t4++)
            for (int t1 = 0; t1 <= t4; t1++)
                for (int t2 = 0; t2 <= t4; t2++)
                    for (int t3 = 0; t3 <= t4; t3++) begin
                        bit init;
                        if (!cfg_valid(t1, t2, t3, t4)) continue;
                        init = 1'((t1 + t2 + t3 + t4) % 2);
                        stage(t1, t2, t3, t4, init);
                        do_load();
                        tick(); tick();
                        chk(err, 1'b0, "R8 valid load");
                        do_start();
                        run_check(t1, t2, t3, t4, init, 2 * t4, "R2 R3 R4 R5 wave");
                        do_stop();
                        chk(pwm_out, lvl_of(t1, t2, t3, t4, init, 0), "R11 stop level");
                    end

        // R8: validation sweep while stopped
        for (int t4 = 0; t4 <= 3; t4++)
            for (int t1 = 0; t1 <= 4; t1++)
                for (int t2 = 0; t2 <= 4; t2++)
                    for (int t3 = 0; t3 <= 4; t3++) begin
                        stage(t1, t2, t3, t4, 1'b0);
                        do_load();
                        chk(err, !cfg_valid(t1, t2, t3, t4), "R8 err flag");
                    end

        // R8: rejected load keeps the active set
        stage(2, 0, 0, 5, 1'b1);
        do_load(); tick(); tick();
        stage(7, 0, 0, 5, 1'b0);
        do_load(); tick(); tick();
        chk(err, 1'b1, "R8 reject");
        do_start();
        run_check(2, 0, 0, 5, 1'b1, 10, "R8 active kept");
        do_stop();

        // R6: staging without load has no effect
        stage(4, 0, 0, 5, 1'b0);
        tick(); tick();
        do_start();
        run_check(2, 0, 0, 5, 1'b1, 10, "R6 staging only");
        do_stop();

        // R7 mid-period load, R11 redundant start
        stage(2, 0, 0, 8, 1'b1);
        do_load(); tick(); tick();
        do_start();
        for (int i = 0; i < 24; i++) begin
            int t1v;
            t1v = (i < 8) ? 2 : 6;
            chk(pwm_out, lvl_of(t1v, 0, 0, 8, 1'b1, i % 8), "R7 R11 boundary load");
            wr_en = 1'b0; load_req = 1'b0; start_req = 1'b0;
            if (i == 3) begin wr_en = 1'b1; wr_sel = 3'd0; wr_data = W'(6); end
            if (i == 4) load_req = 1'b1;
            if (i == 12) start_req = 1'b1;
            tick();
        end
        wr_en = 1'b0; load_req = 1'b0; start_req = 1'b0;
        do_stop();

        // R9 R10 interrupt sequencing with a 4-cycle period
        stage(1, 0, 0, 4, 1'b0);
        do_load(); tick(); tick();
        irq_en_req = 1'b1; tick(); irq_en_req = 1'b0;
        do_start();
        for (int i = 0; i < 26; i++) begin
            irq_en_req = 1'b0; irq_ack = 1'b0; irq_dis_req = 1'b0;
            if (i < 10) chk(irq, 1'b0, "R10 idle enable ignored");
            if (i == 10) chk(irq, 1'b1, "R9 enable shows status");
            if (i == 14) chk(irq, 1'b0, "R9 ack clears");
            if (i == 15) chk(irq, 1'b0, "R9 stays clear");
            if (i == 16) chk(irq, 1'b1, "R9 period end sets");
            if (i == 20) chk(irq, 1'b1, "R9 end beats ack");
            if (i == 22) chk(irq, 1'b0, "R10 disable clears");
            if (i == 23) chk(irq, 1'b0, "R10 status cleared by disable");
            if (i == 24) chk(irq, 1'b1, "R9 set after re-enable");
            if (i == 9 || i == 22) irq_en_req = 1'b1;
            if (i == 13 || i == 19) irq_ack = 1'b1;
            if (i == 21) irq_dis_req = 1'b1;
            tick();
        end
        irq_en_req = 1'b0; irq_ack = 1'b0; irq_dis_req = 1'b0;
        do_stop();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule